// File: doc/BRIEF.md
# Serial Sampling Converter Output Emulator

This block is a synthesizable stand-in for the digital serial side of a 16-bit sampling converter. It takes the place of the converter's analog core: a parallel result word comes in on `sample_i`, and the block serves it to a host over a three-wire link. The three wires are an active-low select, a host-driven serial clock and a data line that can be disabled. All activity is sampled on the system clock `clk_i`. The serial clock and the select are edge-detected against that clock. The bench therefore drives them slowly compared with `clk_i`.

Pulling the select low starts a frame. While the select stays high the block stays in shutdown and does not drive the data line. Each falling edge of the serial clock advances a saturating edge count. The result word is latched on the sixth falling edge, which is the end of acquisition. The data line then gives eight zeros followed by the 16 result bits, MSB first, so that a host sampling on rising edges collects all 24 bits. Falling edges after the frame is complete give zeros. Raising the select at any time abandons the frame and clears all state.

Top module: `adc_serial_emu`

## Requirements
- R1: While `cs_ni_i` is high at a clock edge, after that edge `powered_o`, `dout_en_o`, `dout_o`, `acquiring_o`, `converting_o` and `frame_done_o` are all 0.
- R2: On the first clock edge that sees `cs_ni_i` low after it was high, the block powers up. After that edge `powered_o`=1, `dout_en_o`=1, `dout_o`=0 and `acquiring_o`=1.
- R3: `sample_i` is captured on the 6th serial-clock falling edge of a frame. Later changes of `sample_i` do not alter the frame. After that edge `acquiring_o`=0 and `converting_o`=1.
- R4: `dout_o` changes only on the clock edge that detects a serial-clock falling edge, or on a select change.
- R5: After falling edge k of a frame, `dout_o` is 0 for k=1..7. For k=8..23 it is bit (23-k) of the captured word, so the MSB comes first and the LSB comes after edge 23.
- R6: `frame_done_o` is 1 for exactly one clock, right after the edge that drives the LSB (falling edge 23).
- R7: Falling edges from the 24th onward give `dout_o`=0 and `converting_o`=0, and they do not change any other output.
- R8: Raising `cs_ni_i` mid-frame aborts the frame at the next clock edge. A following select fall starts a fresh frame with a new capture.
- R9: Coding is straight binary: 0x0000 gives 16 zero data bits, 0xFFFF gives 16 one data bits, and other words go out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Host serial clock, idle low |
| sample_i | input | 16 | Parallel result word standing in for the analog core |
| dout_o | output | 1 | Serial data, forced 0 when not enabled |
| dout_en_o | output | 1 | Data line drive enable (0 = high impedance) |
| powered_o | output | 1 | Block is out of shutdown |
| acquiring_o | output | 1 | Acquisition window is open |
| converting_o | output | 1 | Word captured, frame bits still pending |
| frame_done_o | output | 1 | One-clock pulse after the LSB is driven |

## Verification
A wrong edge count shows up at the data pin within one falling edge. Either the MSB lands off position 8 or the acquiring-to-converting change misses edge 6. The bench checks every bit of each frame, so such a shift is caught in the first frame it affects. A capture taken at the wrong moment sends the inverted word, because the bench flips `sample_i` right after edge 6. State left behind by an abort shows in the first bits of the next frame.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_TAIL = 2'd3
  } adc_phase_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  assign rise_o = ~prev_q & sig_i;
  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/adc_edge_counter.sv
module adc_edge_counter #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LIMIT = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  // saturate so that tail edges keep emitting zeros
  assign cnt_nxt_o = (cnt_q == LIM_C) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              zero_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh_q;
  logic              bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      if (load_i) sh_q <= din_i;
      if (shift_i) begin
        bit_q <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end else if (zero_i) begin
        bit_q <= 1'b0;
      end
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LEAD_ZEROS = 8,
  parameter int unsigned ACQ_EDGES  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic              powered_o,
  output logic              acquiring_o,
  output logic              converting_o,
  output logic              frame_done_o
);
  localparam int unsigned FRAME_LEN = LEAD_ZEROS + DATA_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] ACQ_C   = CNT_W'(ACQ_EDGES);
  localparam logic [CNT_W-1:0] LOAD_C  = CNT_W'(ACQ_EDGES - 1);
  localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(LEAD_ZEROS);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LSB_C   = CNT_W'(FRAME_LEN - 1);

  logic             cs_rise, cs_fall;
  logic             sclk_rise, sclk_fall;
  logic             active_q, done_q;
  logic             tick, clr;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             bit_val;
  adc_phase_e       phase;

  adc_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i, .rst_ni, .sig_i(cs_ni_i), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_edge_det #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i, .rst_ni, .sig_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  assign clr  = cs_ni_i | cs_fall;
  assign tick = active_q & sclk_fall & ~cs_ni_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (cs_ni_i)      active_q <= 1'b0;
      else if (cs_fall) active_q <= 1'b1;
      done_q <= tick & ~clr & (cnt_nxt == LSB_C) & (cnt != LSB_C);
    end
  end

  adc_edge_counter #(.CNT_W(CNT_W), .LIMIT(FRAME_LEN)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(tick),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
  );

  adc_result_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .load_i (tick & (cnt == LOAD_C)),
    .shift_i(tick & (cnt != cnt_nxt) & (cnt_nxt >= LEAD_C) & (cnt_nxt < FRAME_C)),
    .zero_i (tick),
    .din_i  (sample_i),
    .bit_o  (bit_val)
  );

  always_comb begin
    if (!active_q)          phase = PH_OFF;
    else if (cnt < ACQ_C)   phase = PH_ACQ;
    else if (cnt < FRAME_C) phase = PH_CONV;
    else                    phase = PH_TAIL;
  end

  assign powered_o    = (phase != PH_OFF);
  assign acquiring_o  = (phase == PH_ACQ);
  assign converting_o = (phase == PH_CONV);
  assign dout_en_o    = powered_o;
  assign dout_o       = powered_o & bit_val;
  assign frame_done_o = done_q & powered_o;

  // raw serial-clock rise and select rise are not needed beyond detection
  logic unused_edges;
  assign unused_edges = sclk_rise ^ cs_rise;
endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni_i,
  input logic sclk_i,
  input logic dout_o,
  input logic dout_en_o,
  input logic powered_o,
  input logic acquiring_o,
  input logic converting_o,
  input logic frame_done_o
);
  logic cs_prev, sclk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_ni_i;
      sclk_prev <= sclk_i;
    end
  end

  a_r1_off_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni_i |=> (!powered_o && !dout_en_o && !dout_o && !frame_done_o));

  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_prev && !cs_ni_i) |=> (powered_o && acquiring_o && !dout_o));

  a_r4_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni_i && !cs_prev && !(sclk_prev && !sclk_i)) |=> $stable(dout_o));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r3_phase_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acquiring_o, converting_o, frame_done_o}) || (converting_o && frame_done_o));

  a_r7_done_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (powered_o && !acquiring_o));
endmodule

bind adc_serial_emu adc_serial_emu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni_i(cs_ni_i), .sclk_i(sclk_i),
  .dout_o(dout_o), .dout_en_o(dout_en_o), .powered_o(powered_o),
  .acquiring_o(acquiring_o), .converting_o(converting_o),
  .frame_done_o(frame_done_o)
);

// File: tb/sim_adc_serial_emu.sv
module sim_adc_serial_emu;
  localparam int CLK_P = 10;
  localparam int NVEC  = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA5C3,
                                         16'h8001, 16'h1234, 16'h7FFE};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sclk = 1'b0;
  logic [15:0] sample = '0;
  logic dout, dout_en, powered, acquiring, converting, frame_done;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_serial_emu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni_i(cs_ni), .sclk_i(sclk),
    .sample_i(sample), .dout_o(dout), .dout_en_o(dout_en),
    .powered_o(powered), .acquiring_o(acquiring), .converting_o(converting),
    .frame_done_o(frame_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sclk_pulse();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk) cs_ni = 1'b1;
    @(negedge clk);
    chk("R1 powered after cs high", powered, 0);
    chk("R1 dout_en after cs high", dout_en, 0);
    chk("R1 dout after cs high", dout, 0);
  endtask

  // abort_at = 0: run full frame plus tail edges
  task automatic run_frame(input logic [15:0] w, input int tail, input int abort_at);
    logic exp_bit;
    logic prev_bit;
    sample = w;
    @(negedge clk) cs_ni = 1'b0;
    @(negedge clk);
    chk("R2 powered", powered, 1);
    chk("R2 dout_en", dout_en, 1);
    chk("R2 dout low", dout, 0);
    chk("R2 acquiring", acquiring, 1);
    for (int k = 1; k <= 24 + tail; k++) begin
      if (abort_at != 0 && k > abort_at) break;
      if (k == 10) begin
        prev_bit = dout;
        @(negedge clk) sclk = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 dout stable while sclk high", dout, prev_bit);
        sclk = 1'b0;
        @(negedge clk);
      end else begin
        sclk_pulse();
      end
      if (k == 5) chk("R3 still acquiring at edge 5", acquiring, 1);
      if (k == 6) begin
        chk("R3 acquiring off", acquiring, 0);
        chk("R3 converting on", converting, 1);
        sample = ~w;
      end
      if (k < 8)       exp_bit = 1'b0;
      else if (k < 24) exp_bit = w[23-k];
      else             exp_bit = 1'b0;
      if (k < 8)       chk("R5 leading zero", dout, exp_bit);
      else if (k < 24) chk("R5 R9 data bit", dout, exp_bit);
      else             chk("R7 trailing zero", dout, exp_bit);
      if (k == 23) chk("R6 frame_done pulse", frame_done, 1);
      if (k == 24) chk("R6 frame_done cleared", frame_done, 0);
      if (k >= 24) begin
        chk("R7 converting off", converting, 0);
        chk("R7 still powered", powered, 1);
      end
    end
    cs_up();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset powered", powered, 0);
    chk("R1 reset dout_en", dout_en, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle dout", dout, 0);
    chk("R1 idle frame_done", frame_done, 0);

    for (int i = 0; i < NVEC; i++) run_frame(VEC[i], i % 3, 0);

    // clocks while deselected are ignored
    sclk_pulse();
    chk("R1 sclk ignored when off", powered, 0);

    // abort mid-frame, then fresh frame with a new word
    run_frame(16'hDEAD, 0, 12);
    chk("R8 aborted powered off", powered, 0);
    run_frame(16'h5A3C, 2, 0);
    run_frame(16'hC001, 0, 3);
    run_frame(16'h0F0F, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule